// File: doc/BRIEF.md
# Row Write Collector with Timed Commit

This unit sits between a serial-memory protocol engine and a byte-wide memory array. When the engine has decoded a write address it raises a load event; each data byte the engine accepts is then placed into a row latch of one page (64 bytes by default). The page number comes from the upper address bits, which stay fixed for the whole transaction, and only the in-page offset moves forward. An offset that passes the end of the page wraps to the start of the same page. A byte that lands on an offset already written replaces the earlier byte.

The collected bytes reach the array only if the engine reports a STOP in the bit slot that directly follows an acknowledged byte. A STOP at any other point throws the pending bytes away. An accepted commit starts a self-timed write cycle. A busy flag rises and stays high for a fixed number of system clocks, set by a parameter. The array write port then receives one write per collected location, lowest offset first, one per clock. Busy falls in the clock after the last write. Offsets that got no byte are left alone in the array. A transaction opened while the write-lock input is high collects nothing and never commits. A synchronous reset discards everything, including a commit that is under way.

Top module: `page_commit_unit`

## Requirements
- R1: While `rst` is high, and in the clock after it, `busy_o` and `arr_we_o` are low. A transaction that was collecting, or a commit that was under way, is dropped: no array write caused by it appears after reset.
- R2: On `evt_load_i`, bits [ADDR_W-1:6] of `evt_addr_i` select the page and bits [5:0] give the first offset. Every later write of that transaction carries the same upper bits on `arr_addr_o`.
- R3: Each accepted byte goes to the current offset, and the offset then increments modulo 64. A byte sent past offset 63 goes to offset 0 of the same page. When a location receives several bytes, only the last one is written, and only once.
- R4: A commit starts only on `evt_stop_ack_i` while collecting. `evt_stop_other_i` discards the collected bytes, and busy stays low.
- R5: `busy_o` rises in the clock after the commit STOP. It stays high for WR_CYCLES clocks with no array write. Then one write is issued per clock, and `busy_o` falls in the clock after the last write.
- R6: Only locations that received a byte are written, each exactly once, in ascending offset order, with `arr_data_o` equal to the byte received there.
- R7: If `wr_lock_i` is high with the load event, the transaction accepts no bytes. Its commit STOP starts no write cycle.
- R8: While busy, load, byte and STOP events are ignored. The writes of the running cycle are unchanged, and no later cycle results from them.
- R9: A transaction with a single data byte produces exactly one write at the loaded address, after the same WR_CYCLES wait.
- R10: A commit STOP after a load event with no byte accepted starts no write cycle.
- R11: A load event during collection restarts the transaction. Bytes collected before it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_load_i | input | 1 | Write address decoded, start of a transaction |
| evt_addr_i | input | ADDR_W | Address delivered with the load event |
| wr_lock_i | input | 1 | Write lock level, sampled with the load event |
| evt_byte_i | input | 1 | A data byte was accepted by the engine |
| byte_i | input | 8 | The accepted data byte |
| evt_stop_ack_i | input | 1 | STOP seen in the slot right after an acknowledge |
| evt_stop_other_i | input | 1 | STOP seen at any other point |
| busy_o | output | 1 | Write cycle in progress; engine must ignore the bus |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | 8 | Array write data |

## Verification
The embedded assertions check on every clock the rules that hold locally. These are the offset wrap step, the fixed page during a transaction, the clearing of the location mask on restart, and a busy rise only after a commit STOP. They also cover no commit after a stray STOP or under the write lock, a frozen mask while the timer runs, busy falling only after a write, and quiet outputs after reset. The bench scoreboard shows what only a whole transaction reveals. That is the exact set, order, addresses and data of the array writes, the overwrite of a wrapped location, the exact busy length of WR_CYCLES plus the write count, and the absence of any write after discarded, locked, empty or reset-aborted transactions.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FILL  = 2'd1,
        PH_HOLD  = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;

    typedef struct packed {
        logic load;
        logic accept;
        logic stop_ack;
        logic stop_other;
    } bus_evt_t;

endpackage

// File: rtl/pcu_row_pointer.sv
module pcu_row_pointer #(
    parameter int ADDR_W = 15,
    parameter int OFS_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    step_i,
    output logic [ADDR_W-OFS_W-1:0] row_o,
    output logic [OFS_W-1:0]        ofs_o
);
    localparam int ROW_W = ADDR_W - OFS_W;

    logic [ROW_W-1:0] row_q;
    logic [OFS_W-1:0] ofs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            ofs_q <= '0;
        end else if (load_i) begin
            row_q <= addr_i[ADDR_W-1:OFS_W];
            ofs_q <= addr_i[OFS_W-1:0];
        end else if (step_i) begin
            ofs_q <= ofs_q + 1'b1;
        end
    end

    assign row_o = row_q;
    assign ofs_o = ofs_q;

    // offset advances by one and wraps inside the page
    assert_offset_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> (ofs_o == $past(ofs_o) + 1'b1));

    // page bits never move while bytes stream in
    assert_page_fixed_R2: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> $stable(row_o));

endmodule

// File: rtl/pcu_row_store.sv
module pcu_row_store
    import pcu_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int OFS_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr_i,
    input  logic                  put_i,
    input  logic [OFS_W-1:0]      put_idx_i,
    input  byte_t                 put_data_i,
    input  logic                  take_i,
    input  logic [OFS_W-1:0]      take_idx_i,
    output logic [PAGE_BYTES-1:0] mask_o,
    output byte_t                 rd_data_o
);
    byte_t                 cells [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (put_i && !clr_i) begin
            cells[put_idx_i] <= put_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            mask_q <= '0;
        end else begin
            if (put_i) begin
                mask_q[put_idx_i] <= 1'b1;
            end
            if (take_i) begin
                mask_q[take_idx_i] <= 1'b0;
            end
        end
    end

    assign mask_o    = mask_q;
    assign rd_data_o = cells[take_idx_i];

    // a restart leaves no location marked
    assert_restart_clears_R11: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (mask_o == '0));

    // a stored byte marks its location for the commit
    assert_put_marks_R6: assert property (@(posedge clk) disable iff (rst)
        (put_i && !clr_i) |=> mask_o[$past(put_idx_i)]);

endmodule

// File: rtl/pcu_commit_ctl.sv
module pcu_commit_ctl
    import pcu_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int OFS_W      = 6,
    parameter int WR_CYCLES  = 1000000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  bus_evt_t              evt_i,
    input  logic                  lock_i,
    input  logic [PAGE_BYTES-1:0] mask_i,
    output logic                  load_o,
    output logic                  clr_o,
    output logic                  put_o,
    output logic                  take_o,
    output logic [OFS_W-1:0]      take_idx_o,
    output logic                  busy_o
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);

    phase_e            ph_q, ph_d;
    logic              lock_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              commit_ok;
    logic              last_one;
    logic              collecting;

    function automatic logic [OFS_W-1:0] lowest_idx(input logic [PAGE_BYTES-1:0] m);
        logic [OFS_W-1:0] r;
        r = '0;
        for (int i = PAGE_BYTES - 1; i >= 0; i--) begin
            if (m[i]) r = OFS_W'(i);
        end
        return r;
    endfunction

    assign collecting = (ph_q == PH_FILL);
    assign commit_ok  = (|mask_i) && !lock_q;
    assign last_one   = ((mask_i & (mask_i - 1'b1)) == '0);

    assign load_o = ((ph_q == PH_IDLE) || collecting) && evt_i.load;
    assign clr_o  = load_o ||
                    (collecting && !evt_i.load &&
                     (evt_i.stop_other || (evt_i.stop_ack && !commit_ok)));
    assign put_o  = collecting && !evt_i.load && !evt_i.stop_ack &&
                    !evt_i.stop_other && evt_i.accept && !lock_q;
    assign take_o     = (ph_q == PH_DRAIN);
    assign take_idx_o = lowest_idx(mask_i);
    assign busy_o     = (ph_q == PH_HOLD) || (ph_q == PH_DRAIN);

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: begin
                if (evt_i.load) ph_d = PH_FILL;
            end
            PH_FILL: begin
                if (evt_i.load) begin
                    ph_d = PH_FILL;
                end else if (evt_i.stop_ack) begin
                    ph_d = commit_ok ? PH_HOLD : PH_IDLE;
                end else if (evt_i.stop_other) begin
                    ph_d = PH_IDLE;
                end
            end
            PH_HOLD: begin
                if (cnt_q == CNT_LAST) ph_d = PH_DRAIN;
            end
            PH_DRAIN: begin
                if (last_one) ph_d = PH_IDLE;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            lock_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            ph_q <= ph_d;
            if (load_o) lock_q <= lock_i;
            if (ph_q != PH_HOLD) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
        end
    end

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // busy only ever starts from a commit STOP
    assert_busy_from_stop_R4: assert property (@(posedge clk) disable iff (rst || rst_d)
        $rose(busy_o) |-> $past(evt_i.stop_ack));

    // a STOP outside the acknowledge slot never commits
    assert_stray_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (collecting && evt_i.stop_other && !evt_i.load) |=> !busy_o);

    // a locked transaction never commits
    assert_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (collecting && lock_q && !evt_i.load) |=> !busy_o);

    // bus events cannot disturb the collected set while the timer runs
    assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_HOLD) |=> $stable(mask_i));

    // busy ends only right after an array write
    assert_busy_tail_R5: assert property (@(posedge clk) disable iff (rst || rst_d)
        $fell(busy_o) |-> $past(take_o));

endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit
    import pcu_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 64,
    parameter int WR_CYCLES  = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_load_i,
    input  logic [ADDR_W-1:0] evt_addr_i,
    input  logic              wr_lock_i,
    input  logic              evt_byte_i,
    input  logic [7:0]        byte_i,
    input  logic              evt_stop_ack_i,
    input  logic              evt_stop_other_i,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [7:0]        arr_data_o
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int ROW_W = ADDR_W - OFS_W;

    bus_evt_t              evt;
    logic                  load, clr, put, take;
    logic [OFS_W-1:0]      take_idx;
    logic [PAGE_BYTES-1:0] mask;
    logic [ROW_W-1:0]      row;
    logic [OFS_W-1:0]      ofs;
    byte_t                 rd_data;

    assign evt.load       = evt_load_i;
    assign evt.accept     = evt_byte_i;
    assign evt.stop_ack   = evt_stop_ack_i;
    assign evt.stop_other = evt_stop_other_i;

    pcu_commit_ctl #(
        .PAGE_BYTES (PAGE_BYTES),
        .OFS_W      (OFS_W),
        .WR_CYCLES  (WR_CYCLES)
    ) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .lock_i     (wr_lock_i),
        .mask_i     (mask),
        .load_o     (load),
        .clr_o      (clr),
        .put_o      (put),
        .take_o     (take),
        .take_idx_o (take_idx),
        .busy_o     (busy_o)
    );

    pcu_row_pointer #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .addr_i (evt_addr_i),
        .step_i (put),
        .row_o  (row),
        .ofs_o  (ofs)
    );

    pcu_row_store #(
        .PAGE_BYTES (PAGE_BYTES),
        .OFS_W      (OFS_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (clr),
        .put_i      (put),
        .put_idx_i  (ofs),
        .put_data_i (byte_i),
        .take_i     (take),
        .take_idx_i (take_idx),
        .mask_o     (mask),
        .rd_data_o  (rd_data)
    );

    assign arr_we_o   = take;
    assign arr_addr_o = {row, take_idx};
    assign arr_data_o = rd_data;

    // reset leaves the outputs quiet in the following clock
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy_o && !arr_we_o));

endmodule

// File: tb/page_commit_unit_test.sv
module page_commit_unit_test;
    localparam int AW = 15;
    localparam int W  = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          evt_load_i = 1'b0;
    logic [AW-1:0] evt_addr_i = '0;
    logic          wr_lock_i = 1'b0;
    logic          evt_byte_i = 1'b0;
    logic [7:0]    byte_i = '0;
    logic          evt_stop_ack_i = 1'b0;
    logic          evt_stop_other_i = 1'b0;
    logic          busy_o, arr_we_o;
    logic [AW-1:0] arr_addr_o;
    logic [7:0]    arr_data_o;

    page_commit_unit #(.ADDR_W(AW), .PAGE_BYTES(64), .WR_CYCLES(W)) uut (
        .clk(clk), .rst(rst), .evt_load_i(evt_load_i), .evt_addr_i(evt_addr_i),
        .wr_lock_i(wr_lock_i), .evt_byte_i(evt_byte_i), .byte_i(byte_i),
        .evt_stop_ack_i(evt_stop_ack_i), .evt_stop_other_i(evt_stop_other_i),
        .busy_o(busy_o), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
        .arr_data_o(arr_data_o)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    logic [22:0] exp_q[$];
    logic [7:0]  m_data [64];
    logic [63:0] m_mask = '0;
    logic [8:0]  m_row = '0;
    logic [5:0]  m_ofs = '0;
    bit m_on = 0, m_lock = 0, m_busy = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    // scoreboard monitor
    int  win_cnt = 0, win_wr = 0;
    bit  prev_busy = 0;
    always @(negedge clk) begin
        if (rst) begin
            win_cnt = 0; win_wr = 0; prev_busy = 0;
        end else begin
            if (arr_we_o) begin
                logic [22:0] e;
                chk(busy_o, tag, "write outside busy", 0, 1);
                chk(win_cnt == W + win_wr, tag, "write slot", win_cnt, W + win_wr);
                if (exp_q.size() == 0) begin
                    chk(0, tag, "unexpected write addr", arr_addr_o, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk({arr_addr_o, arr_data_o} == e, tag, "write addr/data",
                        {arr_addr_o, arr_data_o}, e);
                end
                win_wr++;
            end
            if (busy_o) win_cnt++;
            if (!busy_o && prev_busy) begin
                chk(win_cnt == W + win_wr, "R5", "busy length", win_cnt, W + win_wr);
                win_cnt = 0; win_wr = 0; m_busy = 0;
            end
            prev_busy = busy_o;
        end
    end

    task automatic do_load(input logic [AW-1:0] a, input bit lock);
        if (!m_busy) begin
            m_on = 1; m_lock = lock; m_mask = '0;
            m_row = a[14:6]; m_ofs = a[5:0];
        end
        @(negedge clk); evt_load_i = 1; evt_addr_i = a; wr_lock_i = lock;
        @(negedge clk); evt_load_i = 0; wr_lock_i = 0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        if (!m_busy && m_on && !m_lock) begin
            m_data[m_ofs] = d; m_mask[m_ofs] = 1'b1; m_ofs = m_ofs + 1'b1;
        end
        @(negedge clk); evt_byte_i = 1; byte_i = d;
        @(negedge clk); evt_byte_i = 0;
    endtask

    task automatic do_stop_ack();
        if (!m_busy && m_on) begin
            if (!m_lock && m_mask != 0) begin
                for (int k = 0; k < 64; k++)
                    if (m_mask[k]) exp_q.push_back({m_row, 6'(k), m_data[k]});
                m_busy = 1;
            end
            m_on = 0; m_mask = '0;
        end
        @(negedge clk); evt_stop_ack_i = 1;
        @(negedge clk); evt_stop_ack_i = 0;
    endtask

    task automatic do_stop_other();
        if (!m_busy) begin m_on = 0; m_mask = '0; end
        @(negedge clk); evt_stop_other_i = 1;
        @(negedge clk); evt_stop_other_i = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        m_on = 0; m_mask = '0; m_busy = 0; exp_q.delete();
        repeat (2) @(negedge clk);
        chk(!busy_o && !arr_we_o, "R1", "outputs in reset", {busy_o, arr_we_o}, 0);
        rst = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic drained(input string req);
        chk(exp_q.size() == 0, req, "writes still owed", exp_q.size(), 0);
    endtask

    task automatic quiet(input string req, input int n);
        bit seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (busy_o || arr_we_o) seen = 1;
        end
        chk(!seen, req, "activity where none expected", seen, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !arr_we_o, "R1", "reset state", {busy_o, arr_we_o}, 0);
        rst = 0;

        tag = "R2";  // page bits kept, offsets ascend
        do_load(15'h1234, 0);
        do_byte(8'hA1); do_byte(8'hB2); do_byte(8'hC3);
        do_stop_ack(); wait_idle(); drained("R6");

        tag = "R9";  // single byte
        do_load(15'h7FC0, 0);
        do_byte(8'h5A);
        do_stop_ack(); wait_idle(); drained("R9");

        tag = "R3";  // wrap from offset 62 inside the page
        do_load(15'h02BE, 0);
        for (int i = 0; i < 4; i++) do_byte(8'h10 + 8'(i));
        do_stop_ack(); wait_idle(); drained("R3");

        tag = "R3";  // 66 bytes: offsets 0 and 1 overwritten
        do_load(15'h4100, 0);
        for (int i = 0; i < 66; i++) do_byte(8'(i * 3 + 1));
        do_stop_ack(); wait_idle(); drained("R3");

        tag = "R4";
        do_load(15'h0040, 0);
        do_byte(8'h77); do_byte(8'h88);
        do_stop_other(); quiet("R4", W + 10); drained("R4");

        tag = "R7";
        do_load(15'h0100, 1);
        do_byte(8'h11); do_byte(8'h22);
        do_stop_ack(); quiet("R7", W + 10); drained("R7");

        tag = "R10";
        do_load(15'h0200, 0);
        do_stop_ack(); quiet("R10", W + 10); drained("R10");

        tag = "R11";
        do_load(15'h0300, 0);
        do_byte(8'hE1); do_byte(8'hE2);
        do_load(15'h0385, 0);
        do_byte(8'hF5);
        do_stop_ack(); wait_idle(); drained("R11");

        tag = "R8";  // events during the timed wait are ignored
        do_load(15'h0400, 0);
        do_byte(8'h31); do_byte(8'h32);
        do_stop_ack();
        do_load(15'h0500, 0);
        do_byte(8'h99);
        do_stop_ack();
        do_stop_other();
        wait_idle(); drained("R8");
        quiet("R8", W + 10);

        tag = "R1";  // reset during collection
        do_load(15'h0600, 0);
        do_byte(8'h42);
        do_reset();
        do_stop_ack(); quiet("R1", W + 10); drained("R1");

        tag = "R1";  // reset while the commit timer runs
        do_load(15'h0700, 0);
        do_byte(8'h43); do_byte(8'h44);
        do_stop_ack();
        repeat (5) @(negedge clk);
        do_reset();
        quiet("R1", W + 10); drained("R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule